// File: doc/BRIEF.md
# Pin Function and Level Controller with SD Card Routing

This block is a register-mapped controller for 54 general-purpose pins. Software reaches it through a plain 32-bit word bus: byte address, write strobe, read strobe, write data and registered read data. Each pin stores a 3-bit function code, packed ten to a word. A pin level register is changed only through write-only set and clear ports. Each pin also has a registered output line, which follows the level changes only while the pin's code selects output mode.

The block also decides which of two SD host controllers owns the card interface. The deciding input is the function codes of the six-pin group 48 to 53. When all six carry code 0, the primary controller owns the card. When all six carry code 4, the alternate controller owns it. Any mix leaves ownership where it was, so a pin-by-pin reconfiguration does not toggle ownership part way through.

Several addresses belong to pin features this block does not model: edge and level detection, and pull control. Those addresses accept accesses with no effect. Any address outside the map raises a one-cycle error flag.

Top module: `gpio_sd_ctrl`

## Requirements
- R1: After reset, every function code, every stored level and every output line is 0. `sd_route_alt` is 0 (primary controller) and `bad_access` is 0.
- R2: The function word at byte offset 4n (n = 0..5) holds pins 10n..10n+9, with pin 10n+i in bits [3i+2:3i], and it reads back what was written. Bits 31:30 always read 0. In the word at offset 0x14 only bits 11:0 (pins 50..53) are stored; all other bits of that word read 0.
- R3: Writing 1 to bit k of a set port (0x1C bank 0, 0x20 bank 1) makes the stored level of that pin 1. Writing 1 to bit k of a clear port (0x28 bank 0, 0x2C bank 1) makes it 0. Bits written as 0 change nothing, and the level updates whatever the pin's function code. Bank 0 holds pins 0..31 and bank 1 holds pins 32..53 in bits 21:0. The level ports are 0x34 (bank 0) and 0x38 (bank 1), and bits 31:22 of 0x38 read 0.
- R4: Output line p changes only on a set or clear write that changes the stored level of pin p while pin p has function code 1 (output mode); it then takes the new level one cycle after the write. Putting a pin into output mode does not change its output line.
- R5: The set and clear ports read as 0. Writes to the level ports 0x34 and 0x38 change nothing.
- R6: The addresses 0x40, 0x44, 0x4C, 0x50, 0x58, 0x5C, 0x64, 0x68, 0x70, 0x74, 0x7C, 0x80, 0x88, 0x8C, 0x94, 0x98 and 0x9C read as 0. Writes to them have no effect, and accesses to them never raise `bad_access`.
- R7: A read or write to any other address changes nothing and raises `bad_access` for exactly the one cycle after the strobe. A read of such an address returns 0.
- R8: After every function-word write, the routing is updated on the second clock edge after the strobe. All of pins 48..53 at code 0 selects the primary controller (`sd_route_alt` = 0), and all at code 4 selects the alternate controller (1). Any other combination keeps the previous routing.
- R9: `bus_rdata` presents the read result one cycle after the read strobe and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| bus_addr | input | 12 | Byte address of the access (word aligned) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped address |
| pin_out | output | 54 | Registered output line per pin |
| sd_route_alt | output | 1 | SD card owner: 0 primary controller, 1 alternate controller |

## Verification
The checker watches a set of properties on every cycle. Output lines and the routing bit never move without a preceding write. `bad_access` only follows a strobe, and erroneous reads return zero. Unused bits of function and bank-1 level reads stay zero, the write-only ports read zero, and read data holds between strobes. The bench scenarios are needed for the cases that depend on history: routing that holds on a mixed group, an output line that ignores a change into output mode or a set of an already-high level, and the exact packing of codes into words.

// File: rtl/gpio_sd_pkg.sv
package gpio_sd_pkg;

  localparam int unsigned FN_W  = 3;
  localparam int unsigned IDX_W = 4;

  localparam logic [FN_W-1:0] FN_OUTPUT = 3'd1;
  localparam logic [FN_W-1:0] FN_SD_PRI = 3'd0;
  localparam logic [FN_W-1:0] FN_SD_ALT = 3'd4;

  // fixed register map (byte offsets)
  localparam int unsigned OFF_SET       = 'h1C;
  localparam int unsigned OFF_CLR       = 'h28;
  localparam int unsigned OFF_LEVEL     = 'h34;
  localparam int unsigned OFF_DET_BASE  = 'h40;
  localparam int unsigned DET_STRIDE    = 12;
  localparam int unsigned DET_GROUPS    = 7;
  localparam int unsigned OFF_PULL_BASE = 'h94;
  localparam int unsigned PULL_WORDS    = 3;

  typedef enum logic [2:0] {
    ACC_FSEL,
    ACC_SET,
    ACC_CLR,
    ACC_LEVEL,
    ACC_INERT,
    ACC_BAD
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } acc_dec_t;

endpackage

// File: rtl/gpio_sd_decode.sv
module gpio_sd_decode
  import gpio_sd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned FSEL_WORDS = 6,
  parameter int unsigned NUM_BANKS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_dec_t          dec
);

  always_comb begin
    dec.kind = ACC_BAD;
    dec.idx  = '0;
    for (int w = 0; w < FSEL_WORDS; w++) begin
      if (addr == ADDR_W'(4 * w)) begin
        dec.kind = ACC_FSEL;
        dec.idx  = IDX_W'(w);
      end
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(OFF_SET + 4 * b)) begin
        dec.kind = ACC_SET;
        dec.idx  = IDX_W'(b);
      end
      if (addr == ADDR_W'(OFF_CLR + 4 * b)) begin
        dec.kind = ACC_CLR;
        dec.idx  = IDX_W'(b);
      end
      if (addr == ADDR_W'(OFF_LEVEL + 4 * b)) begin
        dec.kind = ACC_LEVEL;
        dec.idx  = IDX_W'(b);
      end
    end
    for (int g = 0; g < DET_GROUPS; g++) begin
      if (addr == ADDR_W'(OFF_DET_BASE + DET_STRIDE * g) ||
          addr == ADDR_W'(OFF_DET_BASE + DET_STRIDE * g + 4)) begin
        dec.kind = ACC_INERT;
      end
    end
    for (int k = 0; k < PULL_WORDS; k++) begin
      if (addr == ADDR_W'(OFF_PULL_BASE + 4 * k)) begin
        dec.kind = ACC_INERT;
      end
    end
  end

endmodule

// File: rtl/gpio_sd_fsel.sv
module gpio_sd_fsel
  import gpio_sd_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned PER_WORD = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SD_FIRST = 48,
  parameter int unsigned SD_COUNT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_word,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [IDX_W-1:0]    rd_word,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] is_out,
  output logic                grp_all_pri,
  output logic                grp_all_alt
);

  localparam int unsigned USED_BITS = PER_WORD * FN_W;

  logic [NUM_PINS-1:0][FN_W-1:0] code_q;
  logic [NUM_PINS-1:0][FN_W-1:0] code_d;
  logic                          unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:USED_BITS];

  always_comb begin
    code_d = code_q;
    if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_word == IDX_W'(p / PER_WORD)) begin
          code_d[p] = wdata[(p % PER_WORD) * FN_W +: FN_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (wr_en) begin
      code_q <= code_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_word == IDX_W'(p / PER_WORD)) begin
        rd_data[(p % PER_WORD) * FN_W +: FN_W] = code_q[p];
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    assign is_out[p] = (code_q[p] == FN_OUTPUT);
  end

  always_comb begin
    grp_all_pri = 1'b1;
    grp_all_alt = 1'b1;
    for (int s = 0; s < SD_COUNT; s++) begin
      if (code_q[SD_FIRST + s] != FN_SD_PRI) grp_all_pri = 1'b0;
      if (code_q[SD_FIRST + s] != FN_SD_ALT) grp_all_alt = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_sd_level.sv
module gpio_sd_level
  import gpio_sd_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    wr_bank,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] is_out,
  input  logic [IDX_W-1:0]    rd_bank,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] pin_out
);

  logic [NUM_PINS-1:0] lev_q, lev_d;
  logic [NUM_PINS-1:0] out_q, out_d;
  logic                upd;

  assign upd = set_en | clr_en;

  always_comb begin
    lev_d = lev_q;
    out_d = out_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (wr_bank == IDX_W'(p / DATA_W) && wdata[p % DATA_W]) begin
        if (set_en) begin
          if (!lev_q[p] && is_out[p]) out_d[p] = 1'b1;
          lev_d[p] = 1'b1;
        end
        if (clr_en) begin
          if (lev_q[p] && is_out[p]) out_d[p] = 1'b0;
          lev_d[p] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lev_q <= '0;
      out_q <= '0;
    end else if (upd) begin
      lev_q <= lev_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_bank == IDX_W'(p / DATA_W)) begin
        rd_data[p % DATA_W] = lev_q[p];
      end
    end
  end

  assign pin_out = out_q;

endmodule

// File: rtl/gpio_sd_route.sv
module gpio_sd_route (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic grp_all_pri,
  input  logic grp_all_alt,
  output logic route_alt
);

  logic route_q, route_d;

  always_comb begin
    route_d = route_q;
    if (grp_all_pri) begin
      route_d = 1'b0;
    end else if (grp_all_alt) begin
      route_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= 1'b0;
    end else if (upd) begin
      route_q <= route_d;
    end
  end

  assign route_alt = route_q;

endmodule

// File: rtl/gpio_sd_ctrl.sv
module gpio_sd_ctrl
  import gpio_sd_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PER_WORD = 10,
  parameter int unsigned SD_FIRST = 48,
  parameter int unsigned SD_COUNT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bad_access,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                sd_route_alt
);

  localparam int unsigned FSEL_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD;
  localparam int unsigned NUM_BANKS  = (NUM_PINS + DATA_W - 1) / DATA_W;

  acc_dec_t            dec;
  logic                fsel_wr, set_en, clr_en;
  logic [DATA_W-1:0]   fsel_rd, lev_rd;
  logic [NUM_PINS-1:0] is_out;
  logic                grp_pri, grp_alt;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                bad_q, bad_d;
  logic                fsel_upd_q;

  gpio_sd_decode #(
    .ADDR_W    (ADDR_W),
    .FSEL_WORDS(FSEL_WORDS),
    .NUM_BANKS (NUM_BANKS)
  ) u_dec (
    .addr(bus_addr),
    .dec (dec)
  );

  assign fsel_wr = bus_wr && (dec.kind == ACC_FSEL);
  assign set_en  = bus_wr && (dec.kind == ACC_SET);
  assign clr_en  = bus_wr && (dec.kind == ACC_CLR);

  gpio_sd_fsel #(
    .NUM_PINS(NUM_PINS),
    .PER_WORD(PER_WORD),
    .DATA_W  (DATA_W),
    .SD_FIRST(SD_FIRST),
    .SD_COUNT(SD_COUNT)
  ) u_fsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (fsel_wr),
    .wr_word    (dec.idx),
    .wdata      (bus_wdata),
    .rd_word    (dec.idx),
    .rd_data    (fsel_rd),
    .is_out     (is_out),
    .grp_all_pri(grp_pri),
    .grp_all_alt(grp_alt)
  );

  gpio_sd_level #(
    .NUM_PINS(NUM_PINS),
    .DATA_W  (DATA_W)
  ) u_lev (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (set_en),
    .clr_en (clr_en),
    .wr_bank(dec.idx),
    .wdata  (bus_wdata),
    .is_out (is_out),
    .rd_bank(dec.idx),
    .rd_data(lev_rd),
    .pin_out(pin_out)
  );

  gpio_sd_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (fsel_upd_q),
    .grp_all_pri(grp_pri),
    .grp_all_alt(grp_alt),
    .route_alt  (sd_route_alt)
  );

  always_comb begin
    unique case (dec.kind)
      ACC_FSEL:  rdata_d = fsel_rd;
      ACC_LEVEL: rdata_d = lev_rd;
      default:   rdata_d = '0;
    endcase
    bad_d = (bus_rd || bus_wr) && (dec.kind == ACC_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      bad_q      <= 1'b0;
      fsel_upd_q <= 1'b0;
    end else begin
      bad_q      <= bad_d;
      fsel_upd_q <= fsel_wr;
      if (bus_rd) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bad_access = bad_q;

endmodule

// File: rtl/gpio_sd_ctrl_chk.sv
module gpio_sd_ctrl_chk #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bad_access,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                sd_route_alt
);

  AST_FSEL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr < ADDR_W'('h18)) |-> bus_rdata[31:30] == 2'b00); // R2

  AST_BANK1_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'('h38)) |-> bus_rdata[31:22] == '0); // R3

  AST_OUT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != $past(pin_out)) |-> $past(bus_wr)); // R4

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr == ADDR_W'('h1C) || bus_addr == ADDR_W'('h20) ||
                     bus_addr == ADDR_W'('h28) || bus_addr == ADDR_W'('h2C)))
    |-> bus_rdata == '0); // R5

  AST_BAD_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(bus_rd || bus_wr)); // R7

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_access && $past(bus_rd)) |-> bus_rdata == '0); // R7

  AST_ROUTE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_route_alt) |-> $past(bus_wr, 2)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R9

endmodule

bind gpio_sd_ctrl gpio_sd_ctrl_chk #(
  .NUM_PINS(NUM_PINS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .bad_access  (bad_access),
  .pin_out     (pin_out),
  .sd_route_alt(sd_route_alt)
);

// File: tb/gpio_sd_ctrl_test.sv
module gpio_sd_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bad_access;
  logic [53:0] pin_out;
  logic        sd_route_alt;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] exp_q[$];
  logic [11:0] adr_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  gpio_sd_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bad_access  (bad_access),
    .pin_out     (pin_out),
    .sd_route_alt(sd_route_alt)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && rst_n) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R9: unexpected read data %h, expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        logic [11:0] a;
        string       t;
        e = exp_q.pop_front();
        a = adr_q.pop_front();
        t = tag_q.pop_front();
        check($sformatf("%s read @%h", t, a), 64'(bus_rdata), 64'(e));
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    exp_q.push_back(e);
    adr_q.push_back(a);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_out", 64'(pin_out), 64'h0);
    check("R1 route", 64'(sd_route_alt), 64'h0);
    check("R1 bad", 64'(bad_access), 64'h0);
    for (int w = 0; w < 6; w++) rd(12'(4 * w), 32'h0, "R1");
    rd(12'h034, 32'h0, "R1");
    rd(12'h038, 32'h0, "R1");

    // R2 packing and unused bits
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h3FFF_FFFF, "R2");
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, 32'h0000_0FFF, "R2");
    rd(12'h010, 32'h0, "R2");
    wr(12'h000, 32'h0);
    wr(12'h014, 32'h0);
    rd(12'h014, 32'h0, "R2");

    // R3/R4 set, clear, outputs: pin3 and pin40 in output mode
    wr(12'h000, 32'h0000_0200);
    wr(12'h010, 32'h0000_0001);
    rd(12'h000, 32'h0000_0200, "R2");
    wr(12'h01C, 32'h0000_0009);
    check("R4 out after set0", 64'(pin_out), 64'h8);
    rd(12'h034, 32'h0000_0009, "R3");
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h038, 32'h003F_FFFF, "R3");
    check("R4 out after set1", 64'(pin_out), 64'h100_0000_0008);
    wr(12'h028, 32'h0000_0001);
    rd(12'h034, 32'h0000_0008, "R3");
    check("R4 non-output pin clear", 64'(pin_out), 64'h100_0000_0008);
    wr(12'h028, 32'h0);
    rd(12'h034, 32'h0000_0008, "R3");
    wr(12'h02C, 32'h0000_0100);
    rd(12'h038, 32'h003F_FEFF, "R3");
    check("R4 clear pin40", 64'(pin_out), 64'h8);

    // R4 entering output mode, and set of an already-high level
    wr(12'h01C, 32'h0000_0020);
    check("R4 set non-output pin5", 64'(pin_out), 64'h8);
    rd(12'h034, 32'h0000_0028, "R3");
    wr(12'h000, 32'h0000_8200);
    check("R4 mode change keeps line", 64'(pin_out), 64'h8);
    wr(12'h01C, 32'h0000_0020);
    check("R4 set of high level", 64'(pin_out), 64'h8);
    wr(12'h028, 32'h0000_0020);
    check("R4 clear pin5", 64'(pin_out), 64'h8);
    wr(12'h01C, 32'h0000_0020);
    check("R4 set pin5 output", 64'(pin_out), 64'h28);

    // R5 write-only and read-only ports
    rd(12'h01C, 32'h0, "R5");
    rd(12'h02C, 32'h0, "R5");
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h034, 32'h0000_0028, "R5");
    wr(12'h038, 32'h0);
    rd(12'h038, 32'h003F_FEFF, "R5");
    check("R5 out unchanged", 64'(pin_out), 64'h28);

    // R6 inert addresses
    wr(12'h04C, 32'hFFFF_FFFF);
    check("R6 no bad on write", 64'(bad_access), 64'h0);
    rd(12'h04C, 32'h0, "R6");
    check("R6 no bad on read", 64'(bad_access), 64'h0);
    wr(12'h09C, 32'hFFFF_FFFF);
    rd(12'h09C, 32'h0, "R6");
    rd(12'h000, 32'h0000_8200, "R6");
    rd(12'h034, 32'h0000_0028, "R6");
    check("R6 out unchanged", 64'(pin_out), 64'h28);

    // R7 unmapped addresses
    rd(12'h018, 32'h0, "R7");
    check("R7 bad pulse read", 64'(bad_access), 64'h1);
    @(negedge clk);
    check("R7 bad one cycle", 64'(bad_access), 64'h0);
    wr(12'h03C, 32'hFFFF_FFFF);
    check("R7 bad pulse write", 64'(bad_access), 64'h1);
    rd(12'h034, 32'h0000_0028, "R7");
    rd(12'hFFC, 32'h0, "R7");
    check("R7 bad far address", 64'(bad_access), 64'h1);

    // R8 SD routing with hysteresis
    wr(12'h010, 32'h2400_0001);
    idle(1);
    check("R8 partial group holds primary", 64'(sd_route_alt), 64'h0);
    wr(12'h014, 32'h0000_0924);
    check("R8 not before second edge", 64'(sd_route_alt), 64'h0);
    idle(1);
    check("R8 all code4 selects alternate", 64'(sd_route_alt), 64'h1);
    wr(12'h014, 32'h0000_0324);
    idle(1);
    check("R8 mixed holds alternate", 64'(sd_route_alt), 64'h1);
    wr(12'h010, 32'h0000_0001);
    idle(1);
    check("R8 mixed holds alternate again", 64'(sd_route_alt), 64'h1);
    wr(12'h014, 32'h0);
    idle(1);
    check("R8 all code0 selects primary", 64'(sd_route_alt), 64'h0);

    // R9 read data holds between strobes
    rd(12'h034, 32'h0000_0028, "R9");
    idle(3);
    check("R9 rdata holds", 64'(bus_rdata), 64'h28);

    idle(2);
    check("R9 all reads returned", 64'(exp_q.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule